// File: doc/BRIEF.md
# Four-Phase Interleaved Sample Merger

This block takes sample words from two converters that share one analog input and combines them into a single stream in true time order. Each converter samples on both edges of its own clock, and the two clocks are a quarter period apart. That gives four phase-staggered sub-streams per clock period: converter A rising (0°), converter B rising (90°), converter A falling (180°) and converter B falling (270°). When both converters run at 3.2 GS/s, the merged stream carries 6.4 GS/s.

All four sub-streams arrive already captured into one fabric clock domain. Each one delivers `PER_EDGE` 12-bit samples per fabric cycle, with the oldest sample in the low bits. The block zero-extends every sample into a 16-bit lane and places the lanes in time order, oldest in the least significant lane. A group is emitted only when all four sub-streams are valid in the same cycle. A partial group is dropped and raises a sticky flag. A configuration input swaps which converter is treated as the leading phase.

Top module: `quad_phase_merger`

## Requirements
- R1: While reset (active-low, synchronous) is asserted, and at the first clock edge after it, `out_vld`, `out_data` and `misalign` are all zero.
- R2: If all four input valids are high in a cycle, `out_vld` is high in the following cycle, and `out_data` carries that group. Latency is one clock.
- R3: With `lead_swap`=0, input sample k sits at bits [12k+11:12k] of each input vector. Output lane j sits at bits [16j+15:16j]. Lane 4k+0 holds A-rise sample k, lane 4k+1 holds B-rise sample k, lane 4k+2 holds A-fall sample k and lane 4k+3 holds B-fall sample k.
- R4: With `lead_swap`=1, lane 4k+0 holds B-rise sample k, lane 4k+1 holds A-rise sample k, lane 4k+2 holds B-fall sample k and lane 4k+3 holds A-fall sample k.
- R5: Each output lane carries its sample in bits [11:0], and bits [15:12] of every lane are zero.
- R6: If at least one valid is high but not all four, then in the next cycle `out_vld` is low, `out_data` keeps its previous value, and `misalign` is high.
- R7: A cycle with no valid input gives `out_vld` low in the next cycle. It leaves `out_data` and `misalign` unchanged.
- R8: Once set, `misalign` stays high through any later input until reset clears it.
- R9: `lead_swap` is applied to the group presented in the same cycle, so it may change between consecutive groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lead_swap | input | 1 | 1: converter B is the leading phase |
| a_rise_data | input | PER_EDGE*12 | Converter A rising-edge samples, oldest in low bits |
| a_rise_vld | input | 1 | Valid for a_rise_data |
| a_fall_data | input | PER_EDGE*12 | Converter A falling-edge samples |
| a_fall_vld | input | 1 | Valid for a_fall_data |
| b_rise_data | input | PER_EDGE*12 | Converter B rising-edge samples |
| b_rise_vld | input | 1 | Valid for b_rise_data |
| b_fall_data | input | PER_EDGE*12 | Converter B falling-edge samples |
| b_fall_vld | input | 1 | Valid for b_fall_data |
| out_data | output | 4*PER_EDGE*16 | Merged samples in time order, oldest in lane 0 |
| out_vld | output | 1 | out_data holds a new group |
| misalign | output | 1 | Sticky: a partial group was seen |

## Verification
The hardest situation to reach is the one where a partial group arrives between good groups and the merger must drop it. The held data, the missing valid pulse and the sticky flag then all have to be seen at once. The stimulus first runs idle cycles and whole groups to show the flag stays clear. It then lowers exactly one sub-stream valid in a chosen cycle, keeps streaming, and later applies reset mid-run to show that only reset clears the flag. The swap input is toggled on consecutive groups so that the leading phase is checked per cycle rather than as a static setting.

// File: rtl/qpm_pkg.sv
// Shared definitions for the four-phase sample merger.
// Assumes: phase slots are numbered in time order within one converter clock period.
package qpm_pkg;
    localparam int NUM_PHASES = 4;

    typedef enum logic [1:0] {
        PH_LEAD_RISE = 2'd0,
        PH_LAG_RISE  = 2'd1,
        PH_LEAD_FALL = 2'd2,
        PH_LAG_FALL  = 2'd3
    } phase_e;
endpackage

// File: rtl/qpm_widen.sv
// Zero-extends a vector of PER_EDGE samples into lanes of LANE_W bits.
// Assumes: LANE_W > SAMP_W; sample k sits at bits [k*SAMP_W +: SAMP_W].
module qpm_widen #(
    parameter int PER_EDGE = 2,
    parameter int SAMP_W   = 12,
    parameter int LANE_W   = 16
) (
    input  logic [PER_EDGE*SAMP_W-1:0] samp_i,
    output logic [PER_EDGE*LANE_W-1:0] lane_o
);
    localparam int PAD_W = LANE_W - SAMP_W;

    for (genvar k = 0; k < PER_EDGE; k++) begin : g_lane
        // Sample k into the low bits of lane k, upper bits cleared.
        assign lane_o[k*LANE_W +: LANE_W] = {{PAD_W{1'b0}}, samp_i[k*SAMP_W +: SAMP_W]};
    end
endmodule

// File: rtl/qpm_lead_sel.sv
// Chooses which converter supplies the leading phase slots.
// Assumes: swap_i is sampled together with the data it steers.
module qpm_lead_sel #(
    parameter int W = 32
) (
    input  logic         swap_i,
    input  logic [W-1:0] a_rise_i,
    input  logic [W-1:0] a_fall_i,
    input  logic [W-1:0] b_rise_i,
    input  logic [W-1:0] b_fall_i,
    output logic [W-1:0] lead_rise_o,
    output logic [W-1:0] lag_rise_o,
    output logic [W-1:0] lead_fall_o,
    output logic [W-1:0] lag_fall_o
);
    // Route converter A or B into the lead and lag slots.
    always_comb begin
        if (swap_i) begin
            lead_rise_o = b_rise_i;
            lag_rise_o  = a_rise_i;
            lead_fall_o = b_fall_i;
            lag_fall_o  = a_fall_i;
        end else begin
            lead_rise_o = a_rise_i;
            lag_rise_o  = b_rise_i;
            lead_fall_o = a_fall_i;
            lag_fall_o  = b_fall_i;
        end
    end
endmodule

// File: rtl/qpm_group_chk.sv
// Decides whether the four sub-streams form a complete group and keeps a
// sticky flag for partial groups.
// Assumes: only reset clears the flag.
module qpm_group_chk #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] vld_i,
    output logic         complete_o,
    output logic         misalign_o
);
    logic partial;

    // Classify the current cycle's valids.
    always_comb begin
        complete_o = &vld_i;
        partial    = (|vld_i) && !(&vld_i);
    end

    // Sticky capture of any partial group.
    always_ff @(posedge clk) begin
        if (!rst_n)       misalign_o <= 1'b0;
        else if (partial) misalign_o <= 1'b1;
    end
endmodule

// File: rtl/quad_phase_merger.sv
// Merges four phase-staggered sub-streams (two dual-edge converters, clocks a
// quarter period apart) into one time-ordered word of zero-extended lanes.
// Assumes: inputs already in the clk domain; sample 0 of each vector is oldest.
module quad_phase_merger
    import qpm_pkg::*;
#(
    parameter int PER_EDGE = 2,
    parameter int SAMP_W   = 12,
    parameter int LANE_W   = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           lead_swap,
    input  logic [PER_EDGE*SAMP_W-1:0]     a_rise_data,
    input  logic                           a_rise_vld,
    input  logic [PER_EDGE*SAMP_W-1:0]     a_fall_data,
    input  logic                           a_fall_vld,
    input  logic [PER_EDGE*SAMP_W-1:0]     b_rise_data,
    input  logic                           b_rise_vld,
    input  logic [PER_EDGE*SAMP_W-1:0]     b_fall_data,
    input  logic                           b_fall_vld,
    output logic [NUM_PHASES*PER_EDGE*LANE_W-1:0] out_data,
    output logic                           out_vld,
    output logic                           misalign
);
    localparam int VEC_W = PER_EDGE * LANE_W;
    localparam int OUT_W = NUM_PHASES * VEC_W;

    logic [VEC_W-1:0] a_rise_l, a_fall_l, b_rise_l, b_fall_l;
    logic [VEC_W-1:0] lead_rise, lag_rise, lead_fall, lag_fall;
    logic [OUT_W-1:0] merged;
    logic             complete;

    qpm_widen #(.PER_EDGE(PER_EDGE), .SAMP_W(SAMP_W), .LANE_W(LANE_W))
        u_wid_ar (.samp_i(a_rise_data), .lane_o(a_rise_l));
    qpm_widen #(.PER_EDGE(PER_EDGE), .SAMP_W(SAMP_W), .LANE_W(LANE_W))
        u_wid_af (.samp_i(a_fall_data), .lane_o(a_fall_l));
    qpm_widen #(.PER_EDGE(PER_EDGE), .SAMP_W(SAMP_W), .LANE_W(LANE_W))
        u_wid_br (.samp_i(b_rise_data), .lane_o(b_rise_l));
    qpm_widen #(.PER_EDGE(PER_EDGE), .SAMP_W(SAMP_W), .LANE_W(LANE_W))
        u_wid_bf (.samp_i(b_fall_data), .lane_o(b_fall_l));

    qpm_lead_sel #(.W(VEC_W)) u_sel (
        .swap_i     (lead_swap),
        .a_rise_i   (a_rise_l),
        .a_fall_i   (a_fall_l),
        .b_rise_i   (b_rise_l),
        .b_fall_i   (b_fall_l),
        .lead_rise_o(lead_rise),
        .lag_rise_o (lag_rise),
        .lead_fall_o(lead_fall),
        .lag_fall_o (lag_fall)
    );

    qpm_group_chk #(.N(NUM_PHASES)) u_grp (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld_i     ({b_fall_vld, a_fall_vld, b_rise_vld, a_rise_vld}),
        .complete_o(complete),
        .misalign_o(misalign)
    );

    // Interleave: for each sample index, the four phases in time order.
    for (genvar k = 0; k < PER_EDGE; k++) begin : g_slot
        assign merged[(NUM_PHASES*k + int'(PH_LEAD_RISE))*LANE_W +: LANE_W] = lead_rise[k*LANE_W +: LANE_W];
        assign merged[(NUM_PHASES*k + int'(PH_LAG_RISE ))*LANE_W +: LANE_W] = lag_rise [k*LANE_W +: LANE_W];
        assign merged[(NUM_PHASES*k + int'(PH_LEAD_FALL))*LANE_W +: LANE_W] = lead_fall[k*LANE_W +: LANE_W];
        assign merged[(NUM_PHASES*k + int'(PH_LAG_FALL ))*LANE_W +: LANE_W] = lag_fall [k*LANE_W +: LANE_W];
    end

    // Output register: load complete groups only, flag them for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_vld  <= 1'b0;
        end else begin
            out_vld <= complete;
            if (complete) out_data <= merged;
        end
    end
endmodule

// File: rtl/qpm_checker.sv
// Property checker for quad_phase_merger, attached with bind.
// Assumes: same parameter values as the bound instance.
module qpm_checker #(
    parameter int PER_EDGE = 2,
    parameter int SAMP_W   = 12,
    parameter int LANE_W   = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           lead_swap,
    input logic [PER_EDGE*SAMP_W-1:0]     a_rise_data,
    input logic                           a_rise_vld,
    input logic                           a_fall_vld,
    input logic [PER_EDGE*SAMP_W-1:0]     b_rise_data,
    input logic                           b_rise_vld,
    input logic                           b_fall_vld,
    input logic [4*PER_EDGE*LANE_W-1:0]   out_data,
    input logic                           out_vld,
    input logic                           misalign
);
    logic all_in, any_in;
    assign all_in = a_rise_vld & a_fall_vld & b_rise_vld & b_fall_vld;
    assign any_in = a_rise_vld | a_fall_vld | b_rise_vld | b_fall_vld;

    AST_VLD_NEEDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(all_in)); // R2
    AST_GROUP_GIVES_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        all_in |=> out_vld); // R2
    AST_LANE0_NOSWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !$past(lead_swap)) |-> out_data[SAMP_W-1:0] == $past(a_rise_data[SAMP_W-1:0])); // R3
    AST_LANE0_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(lead_swap)) |-> out_data[SAMP_W-1:0] == $past(b_rise_data[SAMP_W-1:0])); // R4
    AST_PARTIAL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (any_in && !all_in) |=> (misalign && !out_vld)); // R6
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !all_in |=> $stable(out_data)); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> misalign); // R8

    for (genvar j = 0; j < 4*PER_EDGE; j++) begin : g_upper
        AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld |-> out_data[j*LANE_W+SAMP_W +: LANE_W-SAMP_W] == '0); // R5
    end
endmodule

bind quad_phase_merger qpm_checker #(
    .PER_EDGE(PER_EDGE), .SAMP_W(SAMP_W), .LANE_W(LANE_W)
) u_qpm_chk (
    .clk(clk), .rst_n(rst_n), .lead_swap(lead_swap),
    .a_rise_data(a_rise_data), .a_rise_vld(a_rise_vld), .a_fall_vld(a_fall_vld),
    .b_rise_data(b_rise_data), .b_rise_vld(b_rise_vld), .b_fall_vld(b_fall_vld),
    .out_data(out_data), .out_vld(out_vld), .misalign(misalign)
);

// File: tb/test_quad_phase_merger.sv
module test_quad_phase_merger;
    localparam int P  = 2;
    localparam int SW = 12;
    localparam int LW = 16;
    localparam int OW = 4 * P * LW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lead_swap = 1'b0;
    logic [P*SW-1:0] a_rise_data = '0, a_fall_data = '0, b_rise_data = '0, b_fall_data = '0;
    logic a_rise_vld = 1'b0, a_fall_vld = 1'b0, b_rise_vld = 1'b0, b_fall_vld = 1'b0;
    logic [OW-1:0] out_data;
    logic out_vld, misalign;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [OW-1:0] exp_data = '0;
    logic exp_vld = 1'b0, exp_mis = 1'b0;

    always #2.5 clk = ~clk;

    quad_phase_merger #(.PER_EDGE(P), .SAMP_W(SW), .LANE_W(LW)) i_quad_phase_merger (
        .clk(clk), .rst_n(rst_n), .lead_swap(lead_swap),
        .a_rise_data(a_rise_data), .a_rise_vld(a_rise_vld),
        .a_fall_data(a_fall_data), .a_fall_vld(a_fall_vld),
        .b_rise_data(b_rise_data), .b_rise_vld(b_rise_vld),
        .b_fall_data(b_fall_data), .b_fall_vld(b_fall_vld),
        .out_data(out_data), .out_vld(out_vld), .misalign(misalign)
    );

    task automatic check(string tag, string what, logic [OW-1:0] act, logic [OW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Compare outputs against the model, then drive the next inputs and advance the model.
    task automatic step(string tag, bit rst, bit swp, bit [3:0] v, bit ones);
        check(tag, "out_vld", OW'(out_vld), OW'(exp_vld));
        check(tag, "out_data", out_data, exp_data);
        check(tag, "misalign", OW'(misalign), OW'(exp_mis));
        rst_n = !rst;
        lead_swap = swp;
        {b_fall_vld, a_fall_vld, b_rise_vld, a_rise_vld} = v;
        a_rise_data = ones ? '1 : P*SW'($urandom);
        a_fall_data = ones ? '1 : P*SW'($urandom);
        b_rise_data = ones ? '1 : P*SW'($urandom);
        b_fall_data = ones ? '1 : P*SW'($urandom);
        if (rst) begin
            exp_data = '0; exp_vld = 0; exp_mis = 0;
        end else if (v == 4'hF) begin
            int q[$];
            for (int k = 0; k < P; k++) begin
                int ar = a_rise_data[k*SW +: SW], br = b_rise_data[k*SW +: SW];
                int af = a_fall_data[k*SW +: SW], bf = b_fall_data[k*SW +: SW];
                if (swp) begin q.push_back(br); q.push_back(ar); q.push_back(bf); q.push_back(af); end
                else     begin q.push_back(ar); q.push_back(br); q.push_back(af); q.push_back(bf); end
            end
            exp_data = '0;
            for (int j = 0; j < q.size(); j++) exp_data[j*LW +: LW] = LW'(q[j]);
            exp_vld = 1'b1;
        end else begin
            exp_vld = 1'b0;
            if (v != 4'h0) exp_mis = 1'b1;
        end
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state, with valid inputs present during reset
        for (int i = 0; i < 3; i++) step("R1", 1, 0, 4'hF, 0);
        // R7: idle cycles leave the flag clear
        for (int i = 0; i < 4; i++) step("R7", 0, 0, 4'h0, 0);
        // R2 R3: whole groups, converter A leading
        for (int i = 0; i < 20; i++) step("R3", 0, 0, 4'hF, 0);
        // R5: all-ones samples, upper lane bits must stay zero
        for (int i = 0; i < 3; i++) step("R5", 0, i[0], 4'hF, 1);
        // R4: converter B leading
        for (int i = 0; i < 20; i++) step("R4", 0, 1, 4'hF, 0);
        // R9: swap toggled on every group
        for (int i = 0; i < 20; i++) step("R9", 0, i[0], 4'hF, 0);
        // R2: gaps between groups
        for (int i = 0; i < 10; i++) step("R2", 0, 0, i[0] ? 4'h0 : 4'hF, 0);
        // R6: one missing valid, data must hold
        step("R6", 0, 0, 4'hF, 0);
        step("R6", 0, 0, 4'hB, 0);
        step("R6", 0, 0, 4'h0, 0);
        step("R6", 0, 0, 4'h1, 0);
        // R8: flag stays through good groups and idle
        for (int i = 0; i < 15; i++) step("R8", 0, i[1], i[2] ? 4'h0 : 4'hF, 0);
        // R8 R1: mid-run reset clears the flag
        step("R8", 1, 0, 4'h7, 0);
        step("R1", 0, 0, 4'h0, 0);
        for (int i = 0; i < 6; i++) step("R8", 0, 0, 4'hF, 0);
        step("R6", 0, 0, 4'hE, 0);
        step("R6", 0, 0, 4'hF, 0);
        step("R8", 0, 0, 4'h0, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule